// File: doc/BRIEF.md
# Temperature Sample Smoothing Filter

This block smooths a stream of temperature readings for one measurement channel with a first-order recursive (exponential) average. Each new reading is compared against the running average. The gap between them is clipped to a programmable bound before a fixed fraction of it is added to the average. A single wild reading therefore moves the result by only a bounded amount. A system with several channels uses one instance per channel.

Readings arrive as signed two's-complement words with a valid strobe. Three static configuration inputs set the behaviour: an enable for averaging, a bit that picks the averaging weight, and a three-bit code that sets the clipping bound. The smoothed reading leaves on a registered output together with its own valid strobe. Internally the average carries four extra fractional bits, so steps smaller than one input LSB still add up over successive readings.

Top module: `temp_avg_filter`

## Requirements
- R1: While reset is asserted and after it is released, `flt_vld_o` is 0 and `flt_o` is 0 until the first accepted reading.
- R2: `flt_vld_o` is high in exactly the cycle after a cycle with `smp_vld_i` high. In every other cycle it is low and `flt_o` holds its value.
- R3: The first reading accepted after reset loads the average directly, without clipping or weighting, and `flt_o` equals that reading.
- R4: With `fast_wt_i` = 0, the average becomes average + clipped_gap/16.
- R5: With `fast_wt_i` = 1, the average becomes average + clipped_gap/4.
- R6: The gap (reading minus average) is clipped to ±(1 << `lim_code_i`) input LSBs in both directions. Codes 0 through 7 therefore give bounds of 1, 2, 4, 8, 16, 32, 64 and 128 LSB.
- R7: With `avg_en_i` = 0, `flt_o` equals the raw reading and the stored average is set to that reading. The next enabled update starts from it.
- R8: The average holds 4 fractional bits. The weighted gap uses an arithmetic (flooring) right shift, and `flt_o` is the average floored to an integer, so negative values round toward minus infinity.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| smp_i | input | SW | Signed temperature reading |
| smp_vld_i | input | 1 | Reading strobe |
| avg_en_i | input | 1 | 1 = average, 0 = pass reading through |
| fast_wt_i | input | 1 | 0 = weight 1/16, 1 = weight 1/4 |
| lim_code_i | input | LCW | Clip bound code, bound = 1 << code LSB |
| flt_o | output | SW | Smoothed reading (floored) |
| flt_vld_o | output | 1 | Result strobe, one cycle after `smp_vld_i` |

## Verification
The bench targets gaps that lie both inside and outside the clip bound, in both signs, for the tightest, the middle and the widest codes. A design with a one-sided or off-by-one clip would drift too far after a spike. Negative averages with fractional parts are checked as well: a design that shifts logically or truncates toward zero would print a value one LSB too high. Three more cases are covered. Full-scale readings on opposite rails expose an overflow in the widened gap. A pass-through followed by an enabled reading shows whether the stored average was really updated. A reseed after reset shows whether the first reading was wrongly clipped.

// File: rtl/temp_avg_filter.sv
module temp_avg_filter #(
  parameter int SW   = 12,
  parameter int FRAC = 4,
  parameter int LCW  = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [SW-1:0] smp_i,
  input  logic          smp_vld_i,
  input  logic          avg_en_i,
  input  logic          fast_wt_i,
  input  logic [LCW-1:0] lim_code_i,
  output logic [SW-1:0] flt_o,
  output logic          flt_vld_o
);
  localparam int AW = SW + FRAC;
  localparam int DW = AW + 1;
  localparam int SLOW_SH = 4;
  localparam int FAST_SH = 2;

  logic signed [AW-1:0] acc;
  logic                 seeded;
  logic signed [DW-1:0] smp_ext, acc_ext, gap, lim, gap_clip, step, acc_sum;
  logic signed [AW-1:0] acc_nxt;

  assign smp_ext = $signed({smp_i[SW-1], smp_i, {FRAC{1'b0}}});
  assign acc_ext = $signed({acc[AW-1], acc});
  assign gap     = smp_ext - acc_ext;
  assign lim     = $signed({{(DW-1){1'b0}}, 1'b1} << (32'(lim_code_i) + FRAC));

  always_comb begin
    if (gap > lim)       gap_clip = lim;
    else if (gap < -lim) gap_clip = -lim;
    else                 gap_clip = gap;
  end

  assign step    = fast_wt_i ? (gap_clip >>> FAST_SH) : (gap_clip >>> SLOW_SH);
  assign acc_sum = acc_ext + step;
  assign acc_nxt = acc_sum[AW-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc       <= '0;
      seeded    <= 1'b0;
      flt_o     <= '0;
      flt_vld_o <= 1'b0;
    end else begin
      flt_vld_o <= smp_vld_i;
      if (smp_vld_i) begin
        seeded <= 1'b1;
        if (!seeded || !avg_en_i) begin
          acc   <= smp_ext[AW-1:0];
          flt_o <= smp_i;
        end else begin
          acc   <= acc_nxt;
          flt_o <= acc_nxt[AW-1:FRAC];
        end
      end
    end
  end
endmodule

// File: rtl/temp_avg_filter_chk.sv
module temp_avg_filter_chk #(
  parameter int SW  = 12,
  parameter int LCW = 3
) (
  input logic           clk,
  input logic           rst_n,
  input logic [SW-1:0]  smp_i,
  input logic           smp_vld_i,
  input logic           avg_en_i,
  input logic [LCW-1:0] lim_code_i,
  input logic [SW-1:0]  flt_o,
  input logic           flt_vld_o,
  input logic           seeded
);
  p_vld_follow_r2: assert property (@(posedge clk) disable iff (!rst_n)
    smp_vld_i |=> flt_vld_o);
  p_vld_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_vld_i |=> !flt_vld_o);
  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_vld_i |=> $stable(flt_o));
  p_seed_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_vld_i && !seeded) |=> flt_o == $past(smp_i));
  p_bypass_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_vld_i && !avg_en_i) |=> flt_o == $past(smp_i));
  p_step_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_vld_i && avg_en_i && seeded) |=>
      ((int'($signed(flt_o)) - int'($signed($past(flt_o)))) <= ((1 << $past(lim_code_i)) / 4 + 1)) &&
      ((int'($signed($past(flt_o))) - int'($signed(flt_o))) <= ((1 << $past(lim_code_i)) / 4 + 1)));
endmodule

bind temp_avg_filter temp_avg_filter_chk #(.SW(SW), .LCW(LCW)) chk_i (
  .clk(clk), .rst_n(rst_n), .smp_i(smp_i), .smp_vld_i(smp_vld_i),
  .avg_en_i(avg_en_i), .lim_code_i(lim_code_i), .flt_o(flt_o),
  .flt_vld_o(flt_vld_o), .seeded(seeded)
);

// File: tb/temp_avg_filter_tb_top.sv
module temp_avg_filter_tb_top;
  localparam int SW = 12;
  localparam int NV = 13;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [SW-1:0] smp_i = '0;
  logic smp_vld_i = 1'b0, avg_en_i = 1'b0, fast_wt_i = 1'b0;
  logic [2:0] lim_code_i = '0;
  logic [SW-1:0] flt_o;
  logic flt_vld_o;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  temp_avg_filter dut_i (
    .clk(clk), .rst_n(rst_n), .smp_i(smp_i), .smp_vld_i(smp_vld_i),
    .avg_en_i(avg_en_i), .fast_wt_i(fast_wt_i), .lim_code_i(lim_code_i),
    .flt_o(flt_o), .flt_vld_o(flt_vld_o)
  );

  // {en, fast, code[2:0], smp[11:0], exp[11:0]}
  function automatic logic [28:0] mk(bit en, bit fast, int code, int smp, int expv);
    return {en, fast, 3'(code), 12'(smp), 12'(expv)};
  endfunction

  localparam logic [28:0] VEC [NV] = '{
    mk(1, 0, 7,   100,   100),  // R3 first reading loads
    mk(1, 0, 7,   116,   101),  // R4 weight 1/16
    mk(1, 1, 7,   116,   104),  // R5 weight 1/4
    mk(1, 1, 2,     0,   103),  // R6 clip negative, code 2
    mk(1, 0, 0,     0,   103),  // R6 clip code 0 with slow weight
    mk(1, 1, 3,   200,   105),  // R6 clip positive, code 3
    mk(0, 0, 0,   -50,   -50),  // R7 pass-through
    mk(1, 1, 7,   -50,   -50),  // R7 average followed raw reading
    mk(1, 1, 7,   -60,   -53),  // R8 floor of negative average
    mk(1, 0, 7,   -60,   -53),  // R8 arithmetic shift of negative gap
    mk(0, 1, 7,  2047,  2047),  // R7 full-scale pass-through
    mk(1, 1, 7, -2048,  2015),  // R6 rail-to-rail gap clipped to 128
    mk(1, 0, 5, -2048,  2013)   // R6 code 5 bound 32, slow weight
  };
  localparam string RQ [NV] = '{"R3","R4","R5","R6","R6","R6","R7","R7","R8","R8","R7","R6","R6"};

  task automatic chk(string rq, logic [SW-1:0] act, logic [SW-1:0] expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", rq, $signed(act), $signed(expv));
    end
  endtask

  task automatic send(bit en, bit fast, int code, int smp, int expv, string rq);
    @(negedge clk);
    avg_en_i = en; fast_wt_i = fast; lim_code_i = 3'(code);
    smp_i = 12'(smp); smp_vld_i = 1'b1;
    @(negedge clk);
    smp_vld_i = 1'b0;
    chk("R2", 12'(flt_vld_o), 12'd1);
    chk(rq, flt_o, 12'(expv));
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual timeout expected finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [SW-1:0] held;
    repeat (3) @(negedge clk);
    chk("R1", flt_o, 12'd0);
    chk("R1", 12'(flt_vld_o), 12'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", flt_o, 12'd0);

    for (int i = 0; i < NV; i++)
      send(VEC[i][28], VEC[i][27], int'(VEC[i][26:24]), int'($signed(VEC[i][23:12])),
           int'($signed(VEC[i][11:0])), RQ[i]);

    // R2: idle cycles hold output and keep strobe low
    held = flt_o;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk("R2", 12'(flt_vld_o), 12'd0);
      chk("R2", flt_o, held);
    end

    // R1/R3: reset then reseed without clipping
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk);
    chk("R1", flt_o, 12'd0);
    chk("R1", 12'(flt_vld_o), 12'd0);
    rst_n = 1'b1;
    send(1, 0, 0, 7, 7, "R3");
    send(1, 1, 0, 9, 7, "R6");   // gap 2 clipped to 1, +1/4 -> 7.25
    send(1, 0, 0, -9, 7, "R6");  // gap clipped to -1, -1/16 -> 7.1875

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule